// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and raises one interrupt line towards the processor. Alongside that line it presents the handler address of the source that won arbitration. Each source holds a programmable priority. A larger value is more urgent, and the value zero keeps the source from ever being delivered. The block has a global enable and a vector base address. The handler address is that base plus four times the index of the winning source.

The processor accepts a delivered interrupt by pulsing `irq_ack` while `irq_o` is high. The controller then records the winner's priority on an in-service stack. It holds the interrupt line low for one cycle so that the same request is not taken twice. The processor pulses `eoi` when a handler ends, and this unwinds one level.

Nesting is off after reset. When nesting is switched on, a request preempts the running handler only if two conditions hold: its priority is strictly greater than the priority on top of the stack, and the stack is below the programmed depth. A four-bit field sets the depth as the number of levels minus one, so its reset value of zero allows a single level and its largest value allows sixteen.

Configuration uses a write-only port with an 8-bit address:
- Addresses 0 to 31 hold the per-source priority in bits [3:0].
- Address 0xF0 holds the control word: bit 0 is the global enable, bit 1 is the nesting enable, and bits [7:4] are the depth field.
- Address 0xF1 holds the vector base.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 0 and `depth_o` is 0; all priorities, the enables, the depth field and the base are 0.
- R2: Among the requests that are high, the source with the numerically largest priority wins. A source whose priority is 0 is never delivered.
- R3: When the largest priority is shared by several sources, the lowest source index wins.
- R4: `vec_o` equals the vector base (address 0xF1) plus 4 times the index of the winning source. It is valid whenever `irq_o` is 1.
- R5: With nesting disabled (control bit 1 = 0), no interrupt is delivered while `depth_o` is nonzero, whatever the priority of the new request.
- R6: With nesting enabled, an interrupt is delivered while `depth_o` is nonzero only if the winning priority is strictly greater than the priority on top of the stack. An equal priority is not delivered.
- R7: With nesting enabled, the level limit equals the control field [7:4] plus 1: one level when the field is 0, sixteen when it is 15. No interrupt is delivered once `depth_o` has reached the limit.
- R8: An `eoi` pulse lowers `depth_o` by one. An `eoi` pulse while `depth_o` is 0 leaves it at 0.
- R9: Requests are level-sensitive. A blocked request that stays high is delivered once it becomes eligible. A request that drops before acceptance is no longer delivered.
- R10: While the global enable (control bit 0) is 0, `irq_o` stays 0.
- R11: An `irq_ack` pulse while `irq_o` is 1 raises `depth_o` by one, and `irq_o` is 0 in the following cycle. Outputs are registered, so they reflect inputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| irq_req | input | 32 | Level-sensitive interrupt requests |
| irq_ack | input | 1 | Processor accepts the delivered interrupt |
| eoi | input | 1 | End of service, unwinds one level |
| irq_o | output | 1 | Interrupt to the processor |
| vec_o | output | 32 | Handler address of the delivered source |
| depth_o | output | 5 | Number of handlers in service |

## Verification
The hardest state to reach is a full stack with the nesting limit exactly reached. In that state an even more urgent request must wait, and it must win as soon as one level unwinds. The stimulus climbs there by raising requests of rising priority one after another and acknowledging each, with a three-level limit. It then raises a priority-15 source and shows that the source is held back until an `eoi`. A separate run raises the limit from one level to sixteen while a blocked request stays high, so that a configuration change alone releases it.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int CFG_AW      = 8;
  localparam int CFG_DW      = 32;
  localparam logic [CFG_AW-1:0] ADR_CTRL = 8'hF0;
  localparam logic [CFG_AW-1:0] ADR_BASE = 8'hF1;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_NEST_BIT = 1;
  localparam int CTRL_LIM_LSB  = 4;
endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int LIM_W   = 4,
  parameter int ADDR_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [CFG_AW-1:0]         addr,
  input  logic [CFG_DW-1:0]         wdata,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      glb_en,
  output logic                      nest_en,
  output logic [LIM_W-1:0]          lim,
  output logic [ADDR_W-1:0]         vec_base
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
    logic [PRIO_W-1:0] p_q;
    always_ff @(posedge clk) begin
      if (rst) p_q <= '0;
      else if (we && addr == CFG_AW'(g)) p_q <= wdata[PRIO_W-1:0];
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = p_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en   <= 1'b0;
      nest_en  <= 1'b0;
      lim      <= '0;
      vec_base <= '0;
    end else if (we) begin
      if (addr == ADR_CTRL) begin
        glb_en  <= wdata[CTRL_EN_BIT];
        nest_en <= wdata[CTRL_NEST_BIT];
        lim     <= wdata[CTRL_LIM_LSB +: LIM_W];
      end
      if (addr == ADR_BASE) vec_base <= wdata[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      best_valid,
  output logic [ID_W-1:0]           best_id,
  output logic [PRIO_W-1:0]         best_prio
);
  always_comb begin
    best_prio = '0;
    best_id   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      // strict compare keeps the lower index on a tie
      if (req[i] && prio_flat[i*PRIO_W +: PRIO_W] > best_prio) begin
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
        best_id   = ID_W'(i);
      end
    end
    best_valid = (best_prio != '0);
  end
endmodule

// File: rtl/nic_stack.sv
module nic_stack #(
  parameter int DEPTH  = 16,
  parameter int PRIO_W = 4,
  localparam int CNT_W = $clog2(DEPTH+1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [CNT_W-1:0]  depth,
  output logic [PRIO_W-1:0] top_prio
);
  logic [PRIO_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  top_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic              do_wr;

  assign top_idx = IDX_W'(depth - CNT_W'(1));
  assign top_prio = (depth == '0) ? '0 : mem[top_idx];

  // a push in the same cycle as a pop replaces the top entry
  assign do_wr  = push && (pop ? 1'b1 : (depth < CNT_W'(DEPTH)));
  assign wr_idx = (pop && depth != '0) ? top_idx : IDX_W'(depth);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_idx] <= push_prio;
  end

  always_ff @(posedge clk) begin
    if (rst) depth <= '0;
    else if (push && !pop && depth < CNT_W'(DEPTH)) depth <= depth + CNT_W'(1);
    else if (pop && !push && depth != '0) depth <= depth - CNT_W'(1);
    else if (push && pop && depth == '0) depth <= CNT_W'(1);
  end

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (rst)
    depth <= CNT_W'(DEPTH));
  p_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
    pop && !push && depth == '0 |=> depth == '0);
  p_pop_one_r8: assert property (@(posedge clk) disable iff (rst)
    pop && !push && depth != '0 |=> depth == $past(depth) - CNT_W'(1));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int PRIO_W    = 4,
  parameter int MAX_DEPTH = 16,
  parameter int ADDR_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [7:0]                        cfg_addr,
  input  logic [31:0]                       cfg_wdata,
  input  logic [NUM_SRC-1:0]                irq_req,
  input  logic                              irq_ack,
  input  logic                              eoi,
  output logic                              irq_o,
  output logic [ADDR_W-1:0]                 vec_o,
  output logic [$clog2(MAX_DEPTH+1)-1:0]    depth_o
);
  localparam int ID_W  = $clog2(NUM_SRC);
  localparam int LIM_W = $clog2(MAX_DEPTH);
  localparam int CNT_W = $clog2(MAX_DEPTH+1);

  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                      glb_en, nest_en;
  logic [LIM_W-1:0]          lim;
  logic [ADDR_W-1:0]         vec_base;
  logic                      best_valid;
  logic [ID_W-1:0]           best_id;
  logic [PRIO_W-1:0]         best_prio;
  logic [PRIO_W-1:0]         top_prio;
  logic [CNT_W-1:0]          depth;
  logic [CNT_W-1:0]          lim_levels;
  logic                      take_ok, push;
  logic [PRIO_W-1:0]         win_prio_q;

  nic_cfg_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .LIM_W(LIM_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .prio_flat(prio_flat), .glb_en(glb_en), .nest_en(nest_en), .lim(lim),
    .vec_base(vec_base));

  nic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .req(irq_req), .prio_flat(prio_flat), .best_valid(best_valid),
    .best_id(best_id), .best_prio(best_prio));

  nic_stack #(.DEPTH(MAX_DEPTH), .PRIO_W(PRIO_W)) u_stk (
    .clk(clk), .rst(rst), .push(push), .push_prio(win_prio_q), .pop(eoi),
    .depth(depth), .top_prio(top_prio));

  assign lim_levels = nest_en ? (CNT_W'(lim) + CNT_W'(1)) : CNT_W'(1);
  assign take_ok = glb_en && best_valid &&
                   (depth == '0 || (depth < lim_levels && best_prio > top_prio));
  assign push = irq_ack && irq_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= 1'b0;
      vec_o      <= '0;
      win_prio_q <= '0;
    end else begin
      irq_o <= take_ok && !push && !eoi;
      if (take_ok) begin
        vec_o      <= vec_base + ADDR_W'({best_id, 2'b00});
        win_prio_q <= best_prio;
      end
    end
  end

  assign depth_o = depth;

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !irq_o);
  p_ack_gap_r11: assert property (@(posedge clk) disable iff (rst)
    irq_ack && irq_o |=> !irq_o);
  p_ack_push_r11: assert property (@(posedge clk) disable iff (rst)
    irq_ack && irq_o && !eoi |=> depth_o == $past(depth_o) + CNT_W'(1));
  p_stray_ack_r11: assert property (@(posedge clk) disable iff (rst)
    irq_ack && !irq_o && !eoi |=> $stable(depth_o));
  p_no_nest_r5: assert property (@(posedge clk) disable iff (rst)
    !nest_en && depth_o != '0 |=> !irq_o);
endmodule

// File: tb/nest_irq_ctrl_tb.sv
`timescale 1ns/100ps
module nest_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] irq_req;
  logic        irq_ack, eoi;
  logic        irq_o;
  logic [31:0] vec_o;
  logic [4:0]  depth_o;

  always #2.5 clk = ~clk;

  nest_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq_req(irq_req), .irq_ack(irq_ack), .eoi(eoi),
    .irq_o(irq_o), .vec_o(vec_o), .depth_o(depth_o));

  typedef struct {
    bit          irq;
    logic [31:0] vec;
    int          depth;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // monitor: compares queued expectations with the outputs at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (irq_o !== e.irq || int'(depth_o) != e.depth || (e.irq && vec_o !== e.vec)) begin
        n_bad++;
        $display("FAIL %s: irq=%0b vec=%h depth=%0d expected irq=%0b vec=%h depth=%0d",
                 e.tag, irq_o, vec_o, depth_o, e.irq, e.vec, e.depth);
      end
    end
  end

  function automatic logic [31:0] vaddr(int i);
    return 32'h1000 + 32'(i) * 4;
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(bit irq, logic [31:0] vec, int depth, string tag);
    exp_t e;
    e.irq = irq; e.vec = vec; e.depth = depth; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    #0.5;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
  endtask

  task automatic end_svc();
    eoi = 1'b1; step(1); eoi = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    irq_req = '0; irq_ack = 1'b0; eoi = 1'b0;
    step(3);
    rst = 1'b0;
    step(1);
    expect_out(1'b0, 32'h0, 0, "R1 reset state");
    if (vec_o !== 32'h0) begin
      n_bad++; $display("FAIL R1: vec=%h expected 0", vec_o);
    end
    n_chk++;

    wr(8'hF1, 32'h1000);
    wr(8'h03, 5); wr(8'h07, 9); wr(8'h0A, 9); wr(8'h14, 2);
    wr(8'h15, 2); wr(8'h0C, 15); wr(8'h05, 0);
    wr(8'hF0, 32'h01);

    irq_req = 32'h0000_0008; step(1);
    expect_out(1'b1, vaddr(3), 0, "R2 R4 single source 3");
    irq_req = (1 << 3) | (1 << 7) | (1 << 10); step(1);
    expect_out(1'b1, vaddr(7), 0, "R3 tie 7 vs 10, beats 3");
    irq_req = (1 << 5); step(1);
    expect_out(1'b0, 32'h0, 0, "R2 priority zero never delivered");
    irq_req = (1 << 3); step(1);
    irq_req = '0; step(1);
    expect_out(1'b0, 32'h0, 0, "R9 dropped request gone");

    wr(8'hF0, 32'h00);
    irq_req = (1 << 7); step(2);
    expect_out(1'b0, 32'h0, 0, "R10 global enable off");
    irq_req = '0;
    wr(8'hF0, 32'h01);

    // no nesting
    irq_req = (1 << 3); step(1);
    expect_out(1'b1, vaddr(3), 0, "R4 src3 before ack");
    ack();
    expect_out(1'b0, 32'h0, 1, "R11 ack gap and depth");
    irq_req = (1 << 3) | (1 << 7); step(2);
    expect_out(1'b0, 32'h0, 1, "R5 nesting disabled blocks src7");
    end_svc();
    expect_out(1'b0, 32'h0, 0, "R8 eoi pops");
    step(1);
    expect_out(1'b1, vaddr(7), 0, "R9 held src7 delivered");
    end_svc();
    expect_out(1'b0, 32'h0, 0, "R8 eoi on empty ignored");
    irq_req = '0; step(1);

    // nesting, limit field 2 -> three levels
    wr(8'hF0, 32'h23);
    irq_req = (1 << 20); step(1);
    expect_out(1'b1, vaddr(20), 0, "R2 src20 base level");
    ack();
    expect_out(1'b0, 32'h0, 1, "R11 depth 1");
    irq_req |= (1 << 21); step(2);
    expect_out(1'b0, 32'h0, 1, "R6 equal priority not nested");
    irq_req |= (1 << 3); step(1);
    expect_out(1'b1, vaddr(3), 1, "R6 higher priority nests");
    ack();
    irq_req |= (1 << 7); step(1);
    expect_out(1'b1, vaddr(7), 2, "R6 second nesting");
    ack();
    irq_req |= (1 << 12); step(2);
    expect_out(1'b0, 32'h0, 3, "R7 limit three reached");
    end_svc();
    expect_out(1'b0, 32'h0, 2, "R8 pop to two");
    step(1);
    expect_out(1'b1, vaddr(12), 2, "R7 src12 after unwind");
    end_svc(); end_svc();
    expect_out(1'b0, 32'h0, 0, "R8 unwound");
    end_svc();
    expect_out(1'b0, 32'h0, 0, "R8 empty pop ignored again");
    irq_req = '0; step(1);

    // default one level, then sixteen levels
    wr(8'hF0, 32'h03);
    irq_req = (1 << 20); step(1);
    ack();
    irq_req |= (1 << 7); step(2);
    expect_out(1'b0, 32'h0, 1, "R7 default one level");
    wr(8'hF0, 32'hF3);
    step(1);
    expect_out(1'b1, vaddr(7), 1, "R7 sixteen levels releases src7");
    irq_req = (1 << 20); step(1);
    expect_out(1'b0, 32'h0, 1, "R9 src7 dropped before ack");

    step(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule